// File: doc/BRIEF.md
# Word-Oriented SPI Master with Register Interface

This block is an SPI master that sits behind a small 16-bit register port. Software sets up the serial clock rate, the sampling edge and the interrupt behaviour. It then loads a transmit word of up to 32 bits as two halves and writes a command register. The command starts either a write word or a read word of 4 to 32 bits. Each of the two operation kinds has its own completion flag. The read flag also makes a freshly captured receive word visible as two 16-bit halves.

While an operation runs, one active-low chip select is driven, chosen by a field of the command. The serial clock is a divided copy of the system clock. Bits are exchanged most significant first: the transmit word goes out on `mosi_o` during both kinds of operation, and only a read word stores what arrives on `miso_i`. A single interrupt line combines the enabled completion flags. Its polarity can be set, and it can be either a level or a one-cycle pulse.

Top module: `spi_word_master`

## Requirements
- R1: After reset every register reads 0, `sclk_o` is 1, every bit of `cs_no` is 1 and `irq_o` is 1.
- R2: Registers are selected by a 3-bit word index: 0 setup-A, 1 setup-B, 2 command, 3 status, 4/5 transmit low/high, 6/7 receive low/high. Setup-A reads back bit 0 (clock enable), bits 3:1 (divisor), bit 4 (write interrupt enable) and bit 5 (read interrupt enable). Setup-B reads back bit 0 (edge), bit 5 (polarity) and bit 10 (trigger). The command register reads back bits 6:2 (length minus one) and bit 7 (select); its start bits read 0.
- R3: Writing the command with bit 1 set starts a write word of L = field+1 bits, where the field is bits 6:2. The low L bits of {TX high, TX low} go out MSB first. Each half period of `sclk_o` lasts divisor+1 system cycles. Status bit 1 sets on the clock edge exactly 2·L·(divisor+1) cycles after the edge that takes the command.
- R4: Command bit 0 starts a read word with the same timing. It samples L bits of `miso_i` MSB first and loads them right-aligned and zero-extended into the receive word (bits 15:0 at index 6, bits 31:16 at index 7). Status bit 0 sets on completion.
- R5: With setup-B bit 0 = 1, `sclk_o` idles low and `miso_i` is sampled on the rising edge. With bit 0 = 0, it idles high and samples on the falling edge. An operation produces exactly L sampling edges.
- R6: During an operation only `cs_no[sel]` is low, where sel is command bit 7; at all other times every chip select is high.
- R7: A start command is ignored while clock enable (setup-A bit 0) is 0, while an operation is in progress, or when the length field is below 3.
- R8: Writing 0 to status clears both flags. If a completion falls in the same cycle, that completion's flag is set and the other flag is cleared.
- R9: Starting an operation clears the completion flag of its own kind and leaves the other flag unchanged.
- R10: In level mode (setup-B bit 10 = 0), the interrupt is active while (write flag AND write enable) OR (read flag AND read enable) holds. Active means `irq_o` = 1 when setup-B bit 5 = 1, and `irq_o` = 0 when it is 0.
- R11: In edge mode (setup-B bit 10 = 1), the interrupt is active for exactly one cycle after that OR rises.
- R12: A command with both start bits set performs a read word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word index |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data (combinational on index) |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_no | output | CS_N | Chip selects, active low |
| irq_o | output | 1 | Interrupt line |

## Verification
Two things can land on the same clock edge: software clearing the status register and the shift engine finishing an operation. The bench starts a write word of known length while a read flag is already set. It then times a write of 0 to status so that it is sampled on exactly the completion edge, which is 2·L·(divisor+1) cycles after the command. The status read afterwards must show the write flag set and the read flag cleared. A set flag shows that the completion won that edge; a cleared read flag shows that the clear still took effect.

// File: rtl/spi_wm_pkg.sv
package spi_wm_pkg;
  localparam int REG_W   = 16;
  localparam int DATA_W  = 2 * REG_W;
  localparam int LEN_W   = $clog2(DATA_W);
  localparam int DIV_W   = 3;
  localparam int MIN_LEN = 3;  // length field minimum (4 bits)

  // setup-A bit positions
  localparam int S1_CLKEN = 0;
  localparam int S1_DIV   = 1;
  localparam int S1_WIE   = 4;
  localparam int S1_RIE   = 5;
  // setup-B bit positions
  localparam int S2_EDGE  = 0;
  localparam int S2_POL   = 5;
  localparam int S2_TRIG  = 10;
  // command bit positions
  localparam int CT_RD    = 0;
  localparam int CT_WR    = 1;
  localparam int CT_LEN   = 2;
  localparam int CT_SEL   = 7;
  // status bit positions
  localparam int ST_RD    = 0;
  localparam int ST_WR    = 1;

  typedef enum logic [2:0] {
    IDX_SET_A = 3'd0,
    IDX_SET_B = 3'd1,
    IDX_CMD   = 3'd2,
    IDX_STAT  = 3'd3,
    IDX_TXL   = 3'd4,
    IDX_TXH   = 3'd5,
    IDX_RXL   = 3'd6,
    IDX_RXH   = 3'd7
  } reg_idx_e;

  typedef struct packed {
    logic             clk_en;
    logic [DIV_W-1:0] div;
    logic             wr_ie;
    logic             rd_ie;
    logic             rise_edge;
    logic             pol_high;
    logic             edge_trig;
  } cfg_t;
endpackage

// File: rtl/spi_wm_regs.sv
module spi_wm_regs
  import spi_wm_pkg::*;
#(
  parameter int SEL_W = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [2:0]        addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  input  logic              done_wr_i,
  input  logic              done_rd_i,
  input  logic              acc_wr_i,
  input  logic              acc_rd_i,
  input  logic [DATA_W-1:0] rx_word_i,
  output cfg_t              cfg_o,
  output logic [LEN_W-1:0]  cmd_len_o,
  output logic [SEL_W-1:0]  cmd_sel_o,
  output logic [DATA_W-1:0] tx_word_o,
  output logic              start_wr_o,
  output logic              start_rd_o,
  output logic              wr_flag_o,
  output logic              rd_flag_o
);
  reg_idx_e          idx;
  cfg_t              cfg_q;
  logic [LEN_W-1:0]  len_q;
  logic [SEL_W-1:0]  sel_q;
  logic [REG_W-1:0]  txl_q, txh_q;
  logic [DATA_W-1:0] rx_q;
  logic              wr_flag_q, rd_flag_q;
  logic              cmd_hit, stat_clr;

  assign idx      = reg_idx_e'(addr_i);
  assign cmd_hit  = we_i && (idx == IDX_CMD);
  assign stat_clr = we_i && (idx == IDX_STAT) && (wdata_i == '0);

  assign start_wr_o = cmd_hit && wdata_i[CT_WR];
  assign start_rd_o = cmd_hit && wdata_i[CT_RD];
  assign cmd_len_o  = wdata_i[CT_LEN +: LEN_W];
  assign cmd_sel_o  = wdata_i[CT_SEL +: SEL_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q     <= '0;
      len_q     <= '0;
      sel_q     <= '0;
      txl_q     <= '0;
      txh_q     <= '0;
      rx_q      <= '0;
      wr_flag_q <= 1'b0;
      rd_flag_q <= 1'b0;
    end else begin
      if (we_i) begin
        unique case (idx)
          IDX_SET_A: begin
            cfg_q.clk_en <= wdata_i[S1_CLKEN];
            cfg_q.div    <= wdata_i[S1_DIV +: DIV_W];
            cfg_q.wr_ie  <= wdata_i[S1_WIE];
            cfg_q.rd_ie  <= wdata_i[S1_RIE];
          end
          IDX_SET_B: begin
            cfg_q.rise_edge <= wdata_i[S2_EDGE];
            cfg_q.pol_high  <= wdata_i[S2_POL];
            cfg_q.edge_trig <= wdata_i[S2_TRIG];
          end
          IDX_CMD: begin
            len_q <= wdata_i[CT_LEN +: LEN_W];
            sel_q <= wdata_i[CT_SEL +: SEL_W];
          end
          IDX_TXL: txl_q <= wdata_i;
          IDX_TXH: txh_q <= wdata_i;
          default: ;
        endcase
      end
      if (done_rd_i) rx_q <= rx_word_i;
      // completion wins over a clear in the same cycle
      wr_flag_q <= done_wr_i | (wr_flag_q & ~stat_clr & ~acc_wr_i);
      rd_flag_q <= done_rd_i | (rd_flag_q & ~stat_clr & ~acc_rd_i);
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (idx)
      IDX_SET_A: begin
        rdata_o[S1_CLKEN]          = cfg_q.clk_en;
        rdata_o[S1_DIV +: DIV_W]   = cfg_q.div;
        rdata_o[S1_WIE]            = cfg_q.wr_ie;
        rdata_o[S1_RIE]            = cfg_q.rd_ie;
      end
      IDX_SET_B: begin
        rdata_o[S2_EDGE] = cfg_q.rise_edge;
        rdata_o[S2_POL]  = cfg_q.pol_high;
        rdata_o[S2_TRIG] = cfg_q.edge_trig;
      end
      IDX_CMD: begin
        rdata_o[CT_LEN +: LEN_W] = len_q;
        rdata_o[CT_SEL +: SEL_W] = sel_q;
      end
      IDX_STAT: begin
        rdata_o[ST_WR] = wr_flag_q;
        rdata_o[ST_RD] = rd_flag_q;
      end
      IDX_TXL: rdata_o = txl_q;
      IDX_TXH: rdata_o = txh_q;
      IDX_RXL: rdata_o = rx_q[REG_W-1:0];
      IDX_RXH: rdata_o = rx_q[DATA_W-1:REG_W];
      default: rdata_o = '0;
    endcase
  end

  assign cfg_o     = cfg_q;
  assign tx_word_o = {txh_q, txl_q};
  assign wr_flag_o = wr_flag_q;
  assign rd_flag_o = rd_flag_q;
endmodule

// File: rtl/spi_wm_clkdiv.sv
module spi_wm_clkdiv
  import spi_wm_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  // one tick per half period of div_i+1 cycles
  assign tick_o = run_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_wm_engine.sv
module spi_wm_engine
  import spi_wm_pkg::*;
#(
  parameter int SEL_W = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clk_en_i,
  input  logic              start_wr_i,
  input  logic              start_rd_i,
  input  logic [LEN_W-1:0]  cmd_len_i,
  input  logic [SEL_W-1:0]  cmd_sel_i,
  input  logic [DATA_W-1:0] tx_word_i,
  input  logic              miso_i,
  input  logic              tick_i,
  output logic              busy_o,
  output logic              phase_o,
  output logic              mosi_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic              acc_wr_o,
  output logic              acc_rd_o,
  output logic              done_wr_o,
  output logic              done_rd_o,
  output logic [DATA_W-1:0] rx_word_o
);
  localparam logic [LEN_W:0]   ONE_BIT = (LEN_W+1)'(1);
  localparam logic [LEN_W-1:0] TOP_BIT = LEN_W'(DATA_W - 1);
  localparam logic [LEN_W-1:0] LEN_MIN = LEN_W'(MIN_LEN);

  logic              busy_q, phase_q, is_rd_q;
  logic [LEN_W:0]    left_q;
  logic [DATA_W-1:0] tx_sh_q, rx_sh_q;
  logic [SEL_W-1:0]  sel_q;
  logic              accept, last, done;
  logic [LEN_W-1:0]  align;

  assign accept   = (start_wr_i | start_rd_i) && clk_en_i && !busy_q
                    && (cmd_len_i >= LEN_MIN);
  assign acc_rd_o = accept && start_rd_i;        // read has priority
  assign acc_wr_o = accept && !start_rd_i;
  assign align    = TOP_BIT - cmd_len_i;
  assign last     = (left_q == ONE_BIT);
  assign done     = busy_q && tick_i && phase_q && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      phase_q <= 1'b0;
      is_rd_q <= 1'b0;
      left_q  <= '0;
      tx_sh_q <= '0;
      rx_sh_q <= '0;
      sel_q   <= '0;
    end else if (accept) begin
      busy_q  <= 1'b1;
      phase_q <= 1'b0;
      is_rd_q <= start_rd_i;
      left_q  <= {1'b0, cmd_len_i} + ONE_BIT;
      tx_sh_q <= tx_word_i << align;
      rx_sh_q <= '0;
      sel_q   <= cmd_sel_i;
    end else if (busy_q && tick_i) begin
      if (!phase_q) begin
        // leading edge: sample
        phase_q <= 1'b1;
        rx_sh_q <= {rx_sh_q[DATA_W-2:0], miso_i};
      end else begin
        // trailing edge: advance
        phase_q <= 1'b0;
        tx_sh_q <= tx_sh_q << 1;
        left_q  <= left_q - ONE_BIT;
        if (last) busy_q <= 1'b0;
      end
    end
  end

  assign busy_o    = busy_q;
  assign phase_o   = phase_q;
  assign mosi_o    = tx_sh_q[DATA_W-1];
  assign sel_o     = sel_q;
  assign done_wr_o = done && !is_rd_q;
  assign done_rd_o = done && is_rd_q;
  assign rx_word_o = rx_sh_q;
endmodule

// File: rtl/spi_wm_irq.sv
module spi_wm_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_flag_i,
  input  logic rd_flag_i,
  input  logic wr_ie_i,
  input  logic rd_ie_i,
  input  logic pol_high_i,
  input  logic edge_trig_i,
  output logic irq_o
);
  logic level, level_q, act;

  assign level = (wr_flag_i & wr_ie_i) | (rd_flag_i & rd_ie_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) level_q <= 1'b0;
    else         level_q <= level;
  end

  assign act   = edge_trig_i ? (level & ~level_q) : level;
  assign irq_o = pol_high_i ? act : ~act;
endmodule

// File: rtl/spi_word_master.sv
module spi_word_master
  import spi_wm_pkg::*;
#(
  parameter int CS_N = 2,
  localparam int SEL_W = (CS_N > 1) ? $clog2(CS_N) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [2:0]       reg_addr_i,
  input  logic [15:0]      reg_wdata_i,
  output logic [15:0]      reg_rdata_o,
  output logic             sclk_o,
  output logic             mosi_o,
  input  logic             miso_i,
  output logic [CS_N-1:0]  cs_no,
  output logic             irq_o
);
  cfg_t              cfg;
  logic [LEN_W-1:0]  cmd_len;
  logic [SEL_W-1:0]  cmd_sel, act_sel;
  logic [DATA_W-1:0] tx_word, rx_word;
  logic              start_wr, start_rd, acc_wr, acc_rd;
  logic              done_wr, done_rd, wr_flag, rd_flag;
  logic              busy, phase, tick, idle_lvl;

  spi_wm_regs #(.SEL_W(SEL_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .rdata_o    (reg_rdata_o),
    .done_wr_i  (done_wr),
    .done_rd_i  (done_rd),
    .acc_wr_i   (acc_wr),
    .acc_rd_i   (acc_rd),
    .rx_word_i  (rx_word),
    .cfg_o      (cfg),
    .cmd_len_o  (cmd_len),
    .cmd_sel_o  (cmd_sel),
    .tx_word_o  (tx_word),
    .start_wr_o (start_wr),
    .start_rd_o (start_rd),
    .wr_flag_o  (wr_flag),
    .rd_flag_o  (rd_flag)
  );

  spi_wm_clkdiv u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy && cfg.clk_en),
    .div_i  (cfg.div),
    .tick_o (tick)
  );

  spi_wm_engine #(.SEL_W(SEL_W)) u_eng (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clk_en_i   (cfg.clk_en),
    .start_wr_i (start_wr),
    .start_rd_i (start_rd),
    .cmd_len_i  (cmd_len),
    .cmd_sel_i  (cmd_sel),
    .tx_word_i  (tx_word),
    .miso_i     (miso_i),
    .tick_i     (tick),
    .busy_o     (busy),
    .phase_o    (phase),
    .mosi_o     (mosi_o),
    .sel_o      (act_sel),
    .acc_wr_o   (acc_wr),
    .acc_rd_o   (acc_rd),
    .done_wr_o  (done_wr),
    .done_rd_o  (done_rd),
    .rx_word_o  (rx_word)
  );

  spi_wm_irq u_irq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_flag_i   (wr_flag),
    .rd_flag_i   (rd_flag),
    .wr_ie_i     (cfg.wr_ie),
    .rd_ie_i     (cfg.rd_ie),
    .pol_high_i  (cfg.pol_high),
    .edge_trig_i (cfg.edge_trig),
    .irq_o       (irq_o)
  );

  // sampling edge is the leading edge away from idle
  assign idle_lvl = ~cfg.rise_edge;
  assign sclk_o   = busy ? (idle_lvl ^ phase) : idle_lvl;

  for (genvar i = 0; i < CS_N; i++) begin : g_cs
    assign cs_no[i] = !(busy && (act_sel == SEL_W'(i)));
  end
endmodule

// File: rtl/spi_wm_chk.sv
module spi_wm_chk #(
  parameter int CS_N = 2
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            reg_we_i,
  input logic [2:0]      reg_addr_i,
  input logic [15:0]     reg_wdata_i,
  input logic [CS_N-1:0] cs_no,
  input logic            sclk_o,
  input logic            irq_o,
  input logic            clk_en,
  input logic            rise_edge,
  input logic            pol_high,
  input logic            edge_trig,
  input logic            done_wr,
  input logic            done_rd,
  input logic            wr_flag,
  input logic            rd_flag
);
  logic stat_zero, irq_on;
  assign stat_zero = reg_we_i && (reg_addr_i == 3'd3) && (reg_wdata_i == 16'h0);
  assign irq_on    = (irq_o == pol_high);

  assert_cs_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_no));

  assert_sclk_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&cs_no) |-> (sclk_o == !rise_edge));

  assert_no_start_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clk_en && (&cs_no)) |=> (&cs_no));

  assert_done_sets_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_wr |=> wr_flag);

  assert_done_sets_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_rd |=> rd_flag);

  assert_status_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_zero && !done_wr && !done_rd) |=> (!wr_flag && !rd_flag));

  assert_irq_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_trig && irq_on) |=> !(edge_trig && $stable(edge_trig) && $stable(pol_high) && irq_on));
endmodule

bind spi_word_master spi_wm_chk #(.CS_N(CS_N)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .cs_no       (cs_no),
  .sclk_o      (sclk_o),
  .irq_o       (irq_o),
  .clk_en      (cfg.clk_en),
  .rise_edge   (cfg.rise_edge),
  .pol_high    (cfg.pol_high),
  .edge_trig   (cfg.edge_trig),
  .done_wr     (done_wr),
  .done_rd     (done_rd),
  .wr_flag     (wr_flag),
  .rd_flag     (rd_flag)
);

// File: tb/spi_word_master_test.sv
module spi_word_master_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        sclk, mosi, miso;
  logic [1:0]  cs_n;
  logic        irq;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  spi_word_master #(.CS_N(2)) uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .sclk_o(sclk), .mosi_o(mosi),
    .miso_i(miso), .cs_no(cs_n), .irq_o(irq)
  );

  // slave model
  logic [31:0] slv = '0;
  logic [31:0] cap = '0;
  int          idx = 0;
  int          lead = 0;
  logic        idle_exp = 1'b1;
  assign miso = slv[idx];

  always @(sclk) begin
    if (cs_n != 2'b11) begin
      if (sclk !== idle_exp) begin
        cap  = {cap[30:0], mosi};
        lead = lead + 1;
      end else if (idx > 0) begin
        idx = idx - 1;
      end
    end
  end

  typedef struct packed {
    logic        rd;
    logic        edge_s;
    logic [2:0]  div;
    logic [5:0]  len;
    logic        sel;
    logic [31:0] tx;
    logic [31:0] slw;
    logic [31:0] exp_mosi;
    logic [31:0] exp_rx;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b0, 1'b0, 3'd0, 6'd8,  1'b0, 32'h0000_00A5, 32'h0000_0000, 32'h0000_00A5, 32'h0},
    '{1'b1, 1'b1, 3'd1, 6'd16, 1'b1, 32'h1234_BEEF, 32'h0000_C3A5, 32'h0000_BEEF, 32'h0000_C3A5},
    '{1'b1, 1'b0, 3'd2, 6'd4,  1'b0, 32'h0000_000F, 32'hFFFF_FFF9, 32'h0000_000F, 32'h0000_0009},
    '{1'b1, 1'b1, 3'd0, 6'd32, 1'b1, 32'h8000_0001, 32'hDEAD_BEEF, 32'h8000_0001, 32'hDEAD_BEEF},
    '{1'b0, 1'b1, 3'd3, 6'd12, 1'b1, 32'hFFFF_F5A3, 32'h0000_0000, 32'h0000_05A3, 32'h0},
    '{1'b1, 1'b0, 3'd0, 6'd20, 1'b0, 32'h000A_BCDE, 32'h0007_1234, 32'h000A_BCDE, 32'h0007_1234}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // called at a negedge; the write is taken at the following posedge
  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    addr  = a;
    wdata = d;
    we    = 1'b1;
    @(negedge clk);
    we    = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog R3 act=timeout exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      chk(v == 16'h0, "R1 reg", 32'(v), 32'h0);
    end
    chk(sclk == 1'b1, "R1 sclk", 32'(sclk), 32'h1);
    chk(cs_n == 2'b11, "R1 cs", 32'(cs_n), 32'h3);
    chk(irq == 1'b1, "R1 irq", 32'(irq), 32'h1);

    // R2 readback
    wr(3'd0, 16'hFFFF); rd(3'd0, v); chk(v == 16'h003F, "R2 setup-A", 32'(v), 32'h3F);
    wr(3'd1, 16'hFFFF); rd(3'd1, v); chk(v == 16'h0421, "R2 setup-B", 32'(v), 32'h421);
    wr(3'd1, 16'h0000);
    wr(3'd2, 16'h00FC); rd(3'd2, v); chk(v == 16'h00FC, "R2 command", 32'(v), 32'hFC);
    chk(cs_n == 2'b11, "R2 no start", 32'(cs_n), 32'h3);
    wr(3'd4, 16'h1357); rd(3'd4, v); chk(v == 16'h1357, "R2 txl", 32'(v), 32'h1357);
    wr(3'd5, 16'h2468); rd(3'd5, v); chk(v == 16'h2468, "R2 txh", 32'(v), 32'h2468);
    wr(3'd0, 16'h0000);

    // R3 R4 R5 R6 R9: table of operations
    for (int i = 0; i < 6; i++) begin
      int L, dv, cyc, ctrl, bitk;
      L    = int'(VECS[i].len);
      dv   = int'(VECS[i].div);
      cyc  = 2 * L * (dv + 1);
      bitk = VECS[i].rd ? 0 : 1;
      ctrl = (int'(VECS[i].sel) << 7) | ((L - 1) << 2) | (VECS[i].rd ? 1 : 2);
      idle_exp = ~VECS[i].edge_s;
      wr(3'd1, {15'h0, VECS[i].edge_s});
      wr(3'd0, 16'((dv << 1) | 1));
      wr(3'd4, VECS[i].tx[15:0]);
      wr(3'd5, VECS[i].tx[31:16]);
      slv  = VECS[i].slw;
      idx  = L - 1;
      cap  = '0;
      lead = 0;
      wr(3'd2, 16'(ctrl));
      repeat (cyc - 1) @(negedge clk);
      rd(3'd3, v);
      chk(v[bitk] == 1'b0, "R9 flag cleared, R3 not early", 32'(v), 32'h0);
      chk(cs_n == (VECS[i].sel ? 2'b01 : 2'b10), "R6 select", 32'(cs_n), VECS[i].sel ? 32'h1 : 32'h2);
      @(negedge clk);
      rd(3'd3, v);
      chk(v[bitk] == 1'b1, VECS[i].rd ? "R4 done flag" : "R3 done flag", 32'(v), 32'(1 << bitk));
      chk(cs_n == 2'b11, "R6 release", 32'(cs_n), 32'h3);
      chk(sclk == idle_exp, "R5 idle level", 32'(sclk), 32'(idle_exp));
      chk(cap == VECS[i].exp_mosi, "R3 mosi word", cap, VECS[i].exp_mosi);
      chk(lead == L, "R5 sample edges", 32'(lead), 32'(L));
      if (VECS[i].rd) begin
        rd(3'd6, v); chk(v == VECS[i].exp_rx[15:0], "R4 rx low", 32'(v), 32'(VECS[i].exp_rx[15:0]));
        rd(3'd7, v); chk(v == VECS[i].exp_rx[31:16], "R4 rx high", 32'(v), 32'(VECS[i].exp_rx[31:16]));
      end
    end

    // R8 clear
    wr(3'd3, 16'h0); rd(3'd3, v); chk(v == 16'h0, "R8 clear", 32'(v), 32'h0);

    // R7 clock disabled
    wr(3'd0, 16'h0000);
    wr(3'd2, 16'((7 << 2) | 2));
    repeat (20) @(negedge clk);
    rd(3'd3, v); chk(v == 16'h0, "R7 clk off status", 32'(v), 32'h0);
    chk(cs_n == 2'b11, "R7 clk off cs", 32'(cs_n), 32'h3);
    // R7 length too short
    wr(3'd0, 16'h0001);
    wr(3'd2, 16'((2 << 2) | 2));
    repeat (10) @(negedge clk);
    rd(3'd3, v); chk(v == 16'h0, "R7 short len", 32'(v), 32'h0);
    chk(cs_n == 2'b11, "R7 short len cs", 32'(cs_n), 32'h3);
    // R7 busy: read start during a write
    wr(3'd2, 16'((7 << 2) | 2));
    wr(3'd2, 16'((7 << 2) | 1));
    repeat (15) @(negedge clk);
    rd(3'd3, v); chk(v == 16'h2, "R7 busy ignore", 32'(v), 32'h2);

    // R9 keep other flag
    wr(3'd2, 16'((3 << 2) | 1));
    repeat (8) @(negedge clk);
    rd(3'd3, v); chk(v == 16'h3, "R9 both set", 32'(v), 32'h3);
    wr(3'd2, 16'((3 << 2) | 2));
    rd(3'd3, v); chk(v == 16'h1, "R9 own kind cleared", 32'(v), 32'h1);
    repeat (8) @(negedge clk);
    rd(3'd3, v); chk(v == 16'h3, "R9 after write", 32'(v), 32'h3);

    // R8 clear on the completion edge
    wr(3'd2, 16'((3 << 2) | 2));
    repeat (7) @(negedge clk);
    wr(3'd3, 16'h0);
    rd(3'd3, v); chk(v == 16'h2, "R8 completion wins", 32'(v), 32'h2);

    // R12 both start bits
    wr(3'd3, 16'h0);
    wr(3'd2, 16'((3 << 2) | 3));
    repeat (8) @(negedge clk);
    rd(3'd3, v); chk(v == 16'h1, "R12 read priority", 32'(v), 32'h1);

    // R10 level interrupt, read flag set
    wr(3'd0, 16'h0021); chk(irq == 1'b0, "R10 rd enable low-active", 32'(irq), 32'h0);
    wr(3'd0, 16'h0011); chk(irq == 1'b1, "R10 rd masked", 32'(irq), 32'h1);
    wr(3'd1, 16'h0020); chk(irq == 1'b0, "R10 high-active idle", 32'(irq), 32'h0);
    wr(3'd0, 16'h0021); chk(irq == 1'b1, "R10 high-active on", 32'(irq), 32'h1);

    // R11 edge interrupt
    wr(3'd3, 16'h0); chk(irq == 1'b0, "R10 cleared", 32'(irq), 32'h0);
    wr(3'd1, 16'h0420);
    wr(3'd0, 16'h0011);
    wr(3'd2, 16'((3 << 2) | 2));
    repeat (7) @(negedge clk);
    chk(irq == 1'b0, "R11 before", 32'(irq), 32'h0);
    @(negedge clk);
    chk(irq == 1'b1, "R11 pulse", 32'(irq), 32'h1);
    @(negedge clk);
    chk(irq == 1'b0, "R11 one cycle", 32'(irq), 32'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule